// File: doc/BRIEF.md
# Multi-Address PMBus Target Decoder

This block sits behind the bit-level engine of an SMBus/PMBus target that drives two output channels. For each transaction the engine hands it the received 7-bit address and the read/write bit, together with a one-cycle valid strobe. The decoder decides whether the device acknowledges. It also reports which of the two channels the following command applies to, as a two-bit mask.

Five kinds of address are recognised at the same time:
- two fixed broadcast addresses, one covering both channels and one that follows the page setting;
- a programmable rail address held per channel;
- a device address assembled from strap pins and a configuration value;
- one direct address per channel.

The decoder keeps the page register and both rail registers. It updates them from a simple command-write strobe, which is applied only after an acknowledged write transaction. Bus timing, command execution and packet error checking belong to other blocks.

Top module: `pmbus_target_decode`

## Requirements
- R1: A write to address 0x5A is acknowledged with mask 2'b11, whatever the page holds, and page_bad is 0.
- R2: A write to address 0x5B is acknowledged, and its mask is the page decode of R3.
- R3: Page decode: 0x00 gives mask 2'b01 (channel 0), 0x01 gives 2'b10 (channel 1), 0xFF gives 2'b11. Any other value gives mask 2'b00 with page_bad=1 and the transaction is still acknowledged. page_bad is 0 for every transaction that does not use the page.
- R4: Rail addresses match only on writes. The mask bit i is set when rail register i equals {1'b0, addr}. A rail value of 0x80 or above never matches. A command with cmd_rail=1 loads cmd_data into the rail register of every channel set in the current mask.
- R5: Address CHAN_ADDR0 (0x30) selects mask 2'b01 and CHAN_ADDR1 (0x31) selects 2'b10. Both are acknowledged for reads and writes, and the page is ignored.
- R6: The device address is {cfg_hi, strap_lo}, where cfg_hi gives bits 6:4 and strap_lo gives bits 3:0. Both are taken while reset is held and are ignored afterwards. Device address reads and writes are acknowledged, with mask from the page decode.
- R7: A read to 0x5A, 0x5B or a rail address is not acknowledged, and the mask is 2'b00.
- R8: When several classes match, the winner is chosen in this order: the broadcast addresses, then the direct channel addresses, then the device address, then the rail addresses.
- R9: An address matching no class gives ack=0, mask 2'b00 and page_bad=0. A command write following a non-acknowledged transaction changes neither the page nor any rail register.
- R10: The outputs change only on the clock edge that samples addr_vld high, and hold otherwise. is_wr equals the inverse of rd for the transaction.
- R11: After reset ack, ch_mask, is_wr and page_bad are 0, the page is 0x00 and both rail registers are 0x80. A command with cmd_rail=0 after an acknowledged write loads cmd_data into the page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_lo | input | 4 | Strapped low address bits, taken during reset |
| cfg_hi | input | 3 | Configured high address bits, taken during reset |
| addr_vld | input | 1 | One-cycle strobe marking a received address |
| addr | input | 7 | Received target address |
| rd | input | 1 | Read/write bit, 1 means read |
| cmd_we | input | 1 | Command write strobe |
| cmd_rail | input | 1 | 1 loads rail registers, 0 loads the page |
| cmd_data | input | 8 | Command data byte |
| ack | output | 1 | Acknowledge decision for the last address |
| ch_mask | output | 2 | Target channel mask, bit i is channel i |
| is_wr | output | 1 | Last transaction is a write |
| page_bad | output | 1 | Paged access with an unsupported page value |

## Verification
Every one of the 128 addresses is tried both as a read and as a write, under a series of register states. These cover each of the four page cases and rail registers that are disabled, equal, distinct, or overlapping the device and direct addresses. Read against write tells the broadcast and rail classes apart from the others. Changing the page separates the paged classes from the fixed ones, and moving the rail values shows whether the matching is per channel. Command writes issued after refused transactions, and strap changes made after reset, show that state is touched only along the allowed paths.

// File: rtl/pmbus_target_decode.sv
module pmbus_target_decode #(
  parameter logic [6:0] GLOBAL_ALL   = 7'h5A,
  parameter logic [6:0] GLOBAL_PAGED = 7'h5B,
  parameter logic [6:0] CHAN_ADDR0   = 7'h30,
  parameter logic [6:0] CHAN_ADDR1   = 7'h31,
  parameter int         NCH          = 2,
  parameter logic [7:0] RAIL_OFF     = 8'h80
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [3:0]     strap_lo,
  input  logic [2:0]     cfg_hi,
  input  logic           addr_vld,
  input  logic [6:0]     addr,
  input  logic           rd,
  input  logic           cmd_we,
  input  logic           cmd_rail,
  input  logic [7:0]     cmd_data,
  output logic           ack,
  output logic [NCH-1:0] ch_mask,
  output logic           is_wr,
  output logic           page_bad
);

  localparam logic [NCH-1:0] ALL_CH = {NCH{1'b1}};

  logic [6:0]     dev_addr;
  logic [7:0]     page;
  logic [7:0]     rail_q [NCH];
  logic [NCH-1:0] rail_hit;
  logic [NCH-1:0] pg_mask;
  logic [NCH-1:0] nx_mask;
  logic           nx_ack, nx_bad;
  logic           hit_all, hit_pgd, hit_c0, hit_c1, hit_dev;
  logic           cmd_ok;

  always_comb begin
    pg_mask = '0;
    if (page == 8'hFF) pg_mask = ALL_CH;
    else if (page < 8'(NCH)) pg_mask[page[0]] = 1'b1;
  end

  for (genvar i = 0; i < NCH; i++) begin : g_rail
    assign rail_hit[i] = !rail_q[i][7] && (rail_q[i][6:0] == addr);
  end

  assign hit_all = addr == GLOBAL_ALL;
  assign hit_pgd = addr == GLOBAL_PAGED;
  assign hit_c0  = addr == CHAN_ADDR0;
  assign hit_c1  = addr == CHAN_ADDR1;
  assign hit_dev = addr == dev_addr;
  assign cmd_ok  = cmd_we && ack && is_wr;

  always_comb begin
    nx_ack  = 1'b0;
    nx_mask = '0;
    nx_bad  = 1'b0;
    if (hit_all) begin
      nx_ack  = !rd;
      nx_mask = rd ? '0 : ALL_CH;
    end else if (hit_pgd) begin
      nx_ack  = !rd;
      nx_mask = rd ? '0 : pg_mask;
      nx_bad  = !rd && (pg_mask == '0);
    end else if (hit_c0) begin
      nx_ack  = 1'b1;
      nx_mask = NCH'(1);
    end else if (hit_c1) begin
      nx_ack  = 1'b1;
      nx_mask = NCH'(2);
    end else if (hit_dev) begin
      nx_ack  = 1'b1;
      nx_mask = pg_mask;
      nx_bad  = pg_mask == '0;
    end else if (|rail_hit) begin
      nx_ack  = !rd;
      nx_mask = rd ? '0 : rail_hit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack      <= 1'b0;
      ch_mask  <= '0;
      is_wr    <= 1'b0;
      page_bad <= 1'b0;
      page     <= 8'h00;
      dev_addr <= {cfg_hi, strap_lo};
      for (int i = 0; i < NCH; i++) rail_q[i] <= RAIL_OFF;
    end else begin
      if (addr_vld) begin
        ack      <= nx_ack;
        ch_mask  <= nx_mask;
        is_wr    <= !rd;
        page_bad <= nx_bad;
      end
      if (cmd_ok && !cmd_rail) page <= cmd_data;
      if (cmd_ok && cmd_rail)
        for (int i = 0; i < NCH; i++)
          if (ch_mask[i]) rail_q[i] <= cmd_data;
    end
  end

  p_bcast_all_r1: assert property (@(posedge clk) disable iff (!rst_n)
    addr_vld && !rd && addr == GLOBAL_ALL |=> ack && ch_mask == ALL_CH && !page_bad);

  p_bcast_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    addr_vld && rd && (addr == GLOBAL_ALL || addr == GLOBAL_PAGED) |=> !ack && ch_mask == '0);

  p_chan_direct_r5: assert property (@(posedge clk) disable iff (!rst_n)
    addr_vld && addr == CHAN_ADDR0 |=> ack && ch_mask == NCH'(1));

  p_bad_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
    page_bad |-> ch_mask == '0 && ack);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_vld |=> $stable(ack) && $stable(ch_mask) && $stable(page_bad));

  p_nack_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ack |=> $stable(page));

  p_nack_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ack |-> ch_mask == '0);

endmodule

// File: tb/test_pmbus_target_decode.sv
module test_pmbus_target_decode;
  localparam int CLK_PERIOD = 10;

  logic       clk = 0, rst_n = 0;
  logic [3:0] strap_lo = 4'h3;
  logic [2:0] cfg_hi = 3'b010;
  logic       addr_vld = 0, rd = 0, cmd_we = 0, cmd_rail = 0;
  logic [6:0] addr = 0;
  logic [7:0] cmd_data = 0;
  logic       ack, is_wr, page_bad;
  logic [1:0] ch_mask;

  int total = 0, bad = 0;
  logic [7:0] m_page = 8'h00, m_r0 = 8'h80, m_r1 = 8'h80;
  localparam logic [6:0] DEV = 7'h23;

  always #(CLK_PERIOD/2) clk = ~clk;

  pmbus_target_decode i_pmbus_target_decode (
    .clk(clk), .rst_n(rst_n), .strap_lo(strap_lo), .cfg_hi(cfg_hi),
    .addr_vld(addr_vld), .addr(addr), .rd(rd), .cmd_we(cmd_we),
    .cmd_rail(cmd_rail), .cmd_data(cmd_data), .ack(ack), .ch_mask(ch_mask),
    .is_wr(is_wr), .page_bad(page_bad));

  function automatic logic [3:0] model(input logic [6:0] a, input logic r);
    logic [1:0] pm, rm;
    logic pb;
    pm = m_page == 8'h00 ? 2'b01 : m_page == 8'h01 ? 2'b10 : m_page == 8'hFF ? 2'b11 : 2'b00;
    pb = pm == 2'b00;
    rm = {!m_r1[7] && m_r1[6:0] == a, !m_r0[7] && m_r0[6:0] == a};
    if (a == 7'h5A) return r ? 4'b0000 : 4'b1011;
    if (a == 7'h5B) return r ? 4'b0000 : {1'b1, pb, pm};
    if (a == 7'h30) return 4'b1001;
    if (a == 7'h31) return 4'b1010;
    if (a == DEV)   return {1'b1, pb, pm};
    if (rm != 0)    return r ? 4'b0000 : {2'b10, rm};
    return 4'b0000;
  endfunction

  function automatic string tag(input logic [6:0] a, input logic r);
    int n;
    n = (a == 7'h5A || a == 7'h5B) + (a == 7'h30 || a == 7'h31) + (a == DEV) +
        ((!m_r0[7] && m_r0[6:0] == a) || (!m_r1[7] && m_r1[6:0] == a));
    if (n > 1) return "R8";
    if (a == 7'h5A) return r ? "R7" : "R1";
    if (a == 7'h5B) return r ? "R7" : (model(a, r)[2] ? "R3" : "R2");
    if (a == 7'h30 || a == 7'h31) return "R5";
    if (a == DEV) return model(a, r)[2] ? "R3" : "R6";
    if (n == 1) return r ? "R7" : "R4";
    return "R9";
  endfunction

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic xact(input logic [6:0] a, input logic r);
    @(negedge clk); addr = a; rd = r; addr_vld = 1;
    @(negedge clk); addr_vld = 0;
  endtask

  task automatic cmd(input logic rail, input logic [7:0] d);
    @(negedge clk); cmd_we = 1; cmd_rail = rail; cmd_data = d;
    @(negedge clk); cmd_we = 0;
  endtask

  task automatic sweep();
    for (int a = 0; a < 128; a++)
      for (int r = 0; r < 2; r++) begin
        xact(7'(a), r[0]);
        check(tag(7'(a), r[0]), {ack, page_bad, ch_mask}, model(7'(a), r[0]));
        check("R10", {3'b0, is_wr}, {3'b0, !r[0]});
      end
  endtask

  task automatic set_page(input logic [7:0] p);
    xact(DEV, 0); cmd(0, p); m_page = p;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++; total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R11", {ack, page_bad, ch_mask}, 4'b0000);
    check("R11", {3'b0, is_wr}, 4'b0000);
    strap_lo = 4'hF; cfg_hi = 3'b111;  // R6: ignored after reset
    sweep();
    // R10: outputs hold while addr_vld low
    xact(7'h30, 0);
    addr = 7'h31; rd = 1;
    repeat (2) @(negedge clk);
    check("R10", {ack, page_bad, ch_mask}, 4'b1001);
    // R4: per-channel rail programming
    xact(7'h30, 0); cmd(1, 8'h44); m_r0 = 8'h44;
    xact(7'h31, 0); cmd(1, 8'h44); m_r1 = 8'h44;
    sweep();
    xact(7'h31, 0); cmd(1, 8'h45); m_r1 = 8'h45;
    sweep();
    // R11: page programming, R3 page decode
    set_page(8'h01); sweep();
    set_page(8'hFF); sweep();
    set_page(8'h07); sweep();
    // R3: rail command under empty mask changes nothing
    xact(7'h5B, 0); cmd(1, 8'h22);
    // R9: command after refused transaction is dropped
    xact(7'h7F, 0); cmd(0, 8'h00);
    xact(7'h5A, 1); cmd(1, 8'h33);
    xact(DEV, 1);
    check("R9", {ack, page_bad, ch_mask}, 4'b1100);
    sweep();
    // R1: broadcast rail write to both channels
    set_page(8'h00);
    xact(7'h5A, 0); cmd(1, 8'h12); m_r0 = 8'h12; m_r1 = 8'h12;
    sweep();
    // R4: disabled rail; R8 overlaps with device and direct addresses
    xact(7'h30, 0); cmd(1, 8'h90); m_r0 = 8'h90;
    sweep();
    xact(7'h30, 0); cmd(1, 8'h23); m_r0 = 8'h23;
    xact(7'h31, 0); cmd(1, 8'h30); m_r1 = 8'h30;
    set_page(8'h01);
    sweep();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule